// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a simple internal request port to an external 8-bit asynchronous static RAM over a narrow pin set. The low address byte and the data byte take turns on one bidirectional bus. An address-latch-enable strobe tells an external transparent latch when to capture the low byte. The high address byte leaves on its own pins. Separate active-low read and write strobes drive the memory, and the read strobe doubles as the memory's output enable. Every edge of every strobe comes from the internal clock, so the bus suits asynchronous parts only.

The address space is cut into a lower and an upper sector at a boundary set by three configuration bits. Each sector has its own 2-bit wait code, so a fast and a slow memory can share the pins. When enabled, a bus keeper drives the last value seen on the bus whenever no agent drives it, so the pads never float.

A request is offered with `req_valid` while `req_ready` is high and is taken on that clock edge. The access then runs one address cycle with ALE high and one address-hold cycle with ALE low. Next comes the strobe phase and, for the longest wait code, one cycle of address hold. `rsp_done` then pulses together with the read data.

Top module: `xmb_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle, with `rd_n` and `wr_n` high and `ale` low. A request is taken only on a clock edge where `req_ready` is high, and `req_ready` stays low from acceptance until the access has finished.
- R2: Each access raises `ale` for exactly one cycle while the low address byte is on `ad_bus`. The bus keeps the low address for one more cycle after `ale` falls, before any strobe goes low. `ahi` carries the upper address byte, stable from the `ale` cycle to the end of the access.
- R3: The strobe stays low for the number of cycles set by the wait code: code 00 gives 1 cycle, 01 gives 2, 10 gives 3, and 11 gives 3. Only code 11 adds one further cycle with both strobes high and the address held, before `rsp_done`.
- R4: The wait code is taken from `cfg_wait_lo` when address bits [15:13] are below `cfg_bound`, and from `cfg_wait_hi` otherwise. A `cfg_bound` of 0 therefore places every address in the upper sector.
- R5: On a write, only `wr_n` goes low. `ad_bus` carries the write data, unchanged, on every cycle that `wr_n` is low.
- R6: On a read, only `rd_n` goes low and the controller does not drive `ad_bus`. The data on the bus during the last low cycle of `rd_n` is returned on `rsp_rdata`.
- R7: `rsp_done` is high for exactly one cycle at the end of each access, and on that cycle `rsp_rdata` holds the read result.
- R8: With `cfg_keep_en` high, whenever neither the controller drives the bus nor `rd_n` is low, `ad_bus` holds the last value it carried: the write data after a write, the read data after a read.
- R9: With `cfg_keep_en` low, the controller leaves `ad_bus` undriven while idle, so another agent can drive it without a conflict.
- R10: After reset, `rd_n` and `wr_n` are high, `ale` is low, `req_ready` is high and `rsp_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock; all strobe timing derives from it |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High while idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` |
| cfg_bound | input | 3 | Sector boundary in units of address bits [15:13] |
| cfg_wait_lo | input | 2 | Wait code for the lower sector |
| cfg_wait_hi | input | 2 | Wait code for the upper sector |
| cfg_keep_en | input | 1 | Bus keeper enable |
| ad_bus | inout | 8 | Shared low-address / data bus |
| ahi | output | 8 | Upper address byte |
| ale | output | 1 | Address latch enable; the latch captures on its falling edge |
| rd_n | output | 1 | Active-low read strobe / memory output enable |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume three things about the environment. Configuration inputs change only while the controller is idle. The memory drives `ad_bus` only while `rd_n` is low. No outside agent drives the bus while the keeper is enabled. The stimulus respects all three: it changes the sector boundary and wait codes only between accesses, and the memory model enables its drivers from `rd_n` alone. It also puts its own driver on the bus only in the idle window after an access run with the keeper disabled. The memory model's access delay always equals the strobe length of the sector being accessed, so read data becomes valid exactly on the last strobe cycle.

// File: rtl/xmb_pkg.sv
// Package: shared types and helpers for the multiplexed memory bus controller.
// Assumes 2-bit wait codes; the decoding below is the single definition of them.
package xmb_pkg;

    // Access sequencer states, in the order they occur during an access.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALE   = 3'd1,
        ST_SETUP = 3'd2,
        ST_STRB  = 3'd3,
        ST_HOLD  = 3'd4
    } seq_state_t;

    // Wait code values: how far the strobe phase is stretched.
    typedef enum logic [1:0] {
        WS_NONE     = 2'b00,
        WS_ONE      = 2'b01,
        WS_TWO      = 2'b10,
        WS_TWO_HOLD = 2'b11
    } wait_code_t;

    // Number of strobe cycles beyond the first one.
    function automatic logic [1:0] extra_cycles(input wait_code_t c);
        logic [1:0] r;
        case (c)
            WS_NONE:     r = 2'd0;
            WS_ONE:      r = 2'd1;
            default:     r = 2'd2;
        endcase
        return r;
    endfunction

    // True when a trailing address-hold cycle follows the strobe.
    function automatic logic needs_hold(input wait_code_t c);
        return (c == WS_TWO_HOLD);
    endfunction

endpackage

// File: rtl/xmb_sector_sel.sv
// Module: sector selector.
// Compares the top BOUND_W address bits with the programmed boundary and
// picks the wait code of the matching sector. Pure combinational logic;
// assumes BOUND_W <= ADDR_W.
module xmb_sector_sel
    import xmb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BOUND_W = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BOUND_W-1:0] bound,
    input  logic [1:0]         wait_lo,
    input  logic [1:0]         wait_hi,
    output wait_code_t         code
);

    localparam int TOP = ADDR_W - 1;

    logic [BOUND_W-1:0] sector_bits;
    logic               in_upper;

    // Decode the sector and choose its wait setting.
    always_comb begin
        sector_bits = addr[TOP -: BOUND_W];
        in_upper    = (sector_bits >= bound);
        code        = in_upper ? wait_code_t'(wait_hi) : wait_code_t'(wait_lo);
    end

endmodule

// File: rtl/xmb_keeper.sv
// Module: bus keeper.
// Remembers the last value seen on the shared bus: the controller's own drive
// value while it drives, or the bus input while the read strobe is low.
// Requests to drive only when enabled, when the controller is not driving and
// when the read strobe is not low; assumes the memory drives only under rd low.
module xmb_keeper #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_en,
    input  logic              ctrl_oe,
    input  logic [DATA_W-1:0] ctrl_val,
    input  logic              rd_active,
    input  logic [DATA_W-1:0] bus_in,
    output logic              keep_oe,
    output logic [DATA_W-1:0] keep_val
);

    logic [DATA_W-1:0] last_q;

    // Track the most recent bus value from whichever agent drove it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (ctrl_oe) begin
            last_q <= ctrl_val;
        end else if (rd_active) begin
            last_q <= bus_in;
        end
    end

    // Drive only into a bus nobody else owns.
    always_comb begin
        keep_oe  = keep_en && !ctrl_oe && !rd_active;
        keep_val = last_q;
    end

    AST_KEEP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_oe && $past(keep_oe)) |-> $stable(keep_val)); // R8

    AST_KEEP_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> !keep_oe); // R8

endmodule

// File: rtl/xmb_seq.sv
// Module: access sequencer.
// Takes one request while idle and runs the ALE, address-hold, strobe and
// optional trailing-hold phases, then returns to idle with a done pulse.
// The wait code is captured at acceptance; configuration may change freely
// while idle. Read data is sampled on the last strobe cycle.
module xmb_seq
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  wait_code_t        req_code,
    input  logic [DATA_W-1:0] bus_in,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-DATA_W-1:0] ahi,
    output logic              drv_oe,
    output logic [DATA_W-1:0] drv_val,
    output logic              rd_active
);

    localparam int HI_W = ADDR_W - DATA_W;

    seq_state_t        state;
    logic [1:0]        cnt;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    wait_code_t        code_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              last_strb;

    // Last strobe cycle: counter reached the extra cycles of the captured code.
    always_comb begin
        last_strb = (state == ST_STRB) && (cnt == extra_cycles(code_q));
    end

    // Phase sequencing, request capture, read sampling and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= 2'd0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            code_q  <= WS_NONE;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        we_q    <= req_we;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        code_q  <= req_code;
                        state   <= ST_ALE;
                    end
                end
                ST_ALE: begin
                    state <= ST_SETUP;
                end
                ST_SETUP: begin
                    cnt   <= 2'd0;
                    state <= ST_STRB;
                end
                ST_STRB: begin
                    if (last_strb) begin
                        if (!we_q) begin
                            rdata_q <= bus_in;
                        end
                        if (needs_hold(code_q)) begin
                            state <= ST_HOLD;
                        end else begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 2'd1;
                    end
                end
                ST_HOLD: begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Pin-level strobes and the controller's own bus drive.
    always_comb begin
        req_ready = (state == ST_IDLE);
        ale       = (state == ST_ALE);
        rd_active = (state == ST_STRB) && !we_q;
        rd_n      = !rd_active;
        wr_n      = !((state == ST_STRB) && we_q);
        drv_oe    = (state == ST_ALE) || (state == ST_SETUP) ||
                    ((state == ST_STRB) && we_q);
        drv_val   = (state == ST_STRB) ? wdata_q : addr_q[DATA_W-1:0];
        ahi       = addr_q[ADDR_W-1 -: HI_W];
        done      = done_q;
        rdata     = rdata_q;
    end

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && !ale)); // R1

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2

    AST_ALE_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (rd_n && wr_n)); // R2

    AST_AHI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !ale) |-> $stable(ahi)); // R2

    AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R6

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> (drv_oe && $stable(drv_val))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R7

endmodule

// File: rtl/xmb_ctrl.sv
// Module: multiplexed external memory bus controller (top).
// Joins the sector selector, access sequencer and bus keeper, and owns the
// single tri-state driver of the shared bus. Assumes the external memory
// drives the bus only while rd_n is low.
module xmb_ctrl
    import xmb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int BOUND_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic [BOUND_W-1:0]       cfg_bound,
    input  logic [1:0]               cfg_wait_lo,
    input  logic [1:0]               cfg_wait_hi,
    input  logic                     cfg_keep_en,
    inout  wire  [DATA_W-1:0]        ad_bus,
    output logic [ADDR_W-DATA_W-1:0] ahi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);

    wait_code_t        sel_code;
    logic              drv_oe;
    logic [DATA_W-1:0] drv_val;
    logic              rd_active;
    logic              keep_oe;
    logic [DATA_W-1:0] keep_val;
    logic              bus_oe;
    logic [DATA_W-1:0] bus_val;

    xmb_sector_sel #(
        .ADDR_W  (ADDR_W),
        .BOUND_W (BOUND_W)
    ) u_sector (
        .addr    (req_addr),
        .bound   (cfg_bound),
        .wait_lo (cfg_wait_lo),
        .wait_hi (cfg_wait_hi),
        .code    (sel_code)
    );

    xmb_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_code  (sel_code),
        .bus_in    (ad_bus),
        .req_ready (req_ready),
        .done      (rsp_done),
        .rdata     (rsp_rdata),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ahi       (ahi),
        .drv_oe    (drv_oe),
        .drv_val   (drv_val),
        .rd_active (rd_active)
    );

    xmb_keeper #(
        .DATA_W (DATA_W)
    ) u_keep (
        .clk       (clk),
        .rst_n     (rst_n),
        .keep_en   (cfg_keep_en),
        .ctrl_oe   (drv_oe),
        .ctrl_val  (drv_val),
        .rd_active (rd_active),
        .bus_in    (ad_bus),
        .keep_oe   (keep_oe),
        .keep_val  (keep_val)
    );

    // Merge the two drive sources into one pad enable and value.
    always_comb begin
        bus_oe  = drv_oe || keep_oe;
        bus_val = drv_oe ? drv_val : keep_val;
    end

    assign ad_bus = bus_oe ? bus_val : {DATA_W{1'bz}};

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe); // R6

endmodule

// File: tb/xmb_ctrl_test.sv
// Bench: models the external address latch and an asynchronous RAM whose
// access delay equals the strobe length of the accessed sector, then runs
// directed corner cases and seeded random traffic.
module xmb_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [2:0]  cfg_bound = 3'd4;
    logic [1:0]  cfg_wait_lo = 2'd0;
    logic [1:0]  cfg_wait_hi = 2'd0;
    logic        cfg_keep_en = 1'b1;
    wire  [7:0]  ad_bus;
    logic [7:0]  ahi;
    logic        ale;
    logic        rd_n;
    logic        wr_n;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // External latch, RAM model and bench-side bus driver.
    logic [7:0] lat_lo = '0;
    logic [7:0] sram [logic [15:0]];
    logic [7:0] shadow [logic [15:0]];
    logic [7:0] sram_dout = '0;
    int         rd_cnt = 0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_val = '0;
    logic [15:0] pool [16];

    assign ad_bus = !rd_n ? sram_dout : 8'bz;
    assign ad_bus = tb_oe ? tb_val : 8'bz;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_bound(cfg_bound),
        .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
        .cfg_keep_en(cfg_keep_en), .ad_bus(ad_bus), .ahi(ahi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n)
    );

    function automatic logic [1:0] code_of(input logic [15:0] a);
        return (a[15:13] >= cfg_bound) ? cfg_wait_hi : cfg_wait_lo;
    endfunction

    function automatic int exp_len(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 3;
    endfunction

    function automatic int exp_hold(input logic [1:0] c);
        return (c == 2'd3) ? 1 : 0;
    endfunction

    function automatic logic [7:0] lookup(input logic [15:0] a);
        return sram.exists(a) ? sram[a] : 8'h00;
    endfunction

    // The latch captures the low byte when ALE falls.
    always @(negedge ale) lat_lo <= ad_bus;

    // RAM: data valid once the read strobe has been low for the access delay;
    // writes take the bus value while the write strobe is low.
    always @(negedge clk) begin
        logic [15:0] a;
        a = {ahi, lat_lo};
        if (!rd_n) begin
            rd_cnt = rd_cnt + 1;
            sram_dout = (rd_cnt >= exp_len(code_of(a))) ? lookup(a) : ~lookup(a);
        end else begin
            rd_cnt = 0;
        end
        if (!wr_n) sram[a] = ad_bus;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access; measures strobe and hold cycles and checks pin behaviour.
    task automatic do_access(input logic we, input logic [15:0] a,
                             input logic [7:0] wd, output logic [7:0] rd,
                             output int slen);
        int ale_c = 0, strb_c = 0, post_c = 0, rdy_bad = 0, wbad = 0;
        int ahi_bad = 0, lat_bad = 0, wrong_strb = 0, n = 0;
        logic [1:0] c;
        c = code_of(a);
        @(negedge clk);
        chk("R1", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~wd;
        while (!rsp_done && n < 40) begin
            if (ale) ale_c++;
            if (!rd_n || !wr_n) begin
                strb_c++;
                if (ahi !== a[15:8]) ahi_bad++;
                if (lat_lo !== a[7:0]) lat_bad++;
                if (we && ad_bus !== wd) wbad++;
                if (we ? !rd_n : !wr_n) wrong_strb++;
            end else if (strb_c > 0) begin
                post_c++;
                if (ahi !== a[15:8]) ahi_bad++;
            end
            if (req_ready) rdy_bad++;
            @(negedge clk);
            n++;
        end
        rd = rsp_rdata;
        slen = strb_c;
        chk("R7", "done reached", rsp_done, 1);
        chk("R1", "ready low while busy", rdy_bad, 0);
        chk("R2", "ale cycles", ale_c, 1);
        chk("R2", "upper address held", ahi_bad, 0);
        chk("R2", "latched low address", lat_bad, 0);
        chk("R3", "strobe cycles", strb_c, exp_len(c));
        chk("R3", "trailing hold cycles", post_c, exp_hold(c));
        if (we) begin
            chk("R5", "write data on bus", wbad, 0);
            chk("R5", "only write strobe", wrong_strb, 0);
            shadow[a] = wd;
        end else begin
            chk("R6", "only read strobe", wrong_strb, 0);
            chk("R6", "read data", rd, shadow.exists(a) ? shadow[a] : 8'h00);
        end
        @(negedge clk);
        chk("R7", "done one cycle", rsp_done, 0);
        if (cfg_keep_en) chk("R8", "keeper value", ad_bus, we ? wd : rd);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int slen;
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "rd_n after reset", rd_n, 1);
        chk("R10", "wr_n after reset", wr_n, 1);
        chk("R10", "ale after reset", ale, 0);
        chk("R10", "ready after reset", req_ready, 1);
        chk("R10", "done after reset", rsp_done, 0);

        // Every wait code in both sectors, boundary at 0x8000.
        cfg_bound = 3'd4;
        for (int c = 0; c < 4; c++) begin
            cfg_wait_lo = 2'(c);
            cfg_wait_hi = 2'(3 - c);
            do_access(1'b1, 16'h1234 + 16'(c), 8'hA0 + 8'(c), rd, slen);
            do_access(1'b1, 16'hC3A5 + 16'(c), 8'h5F - 8'(c), rd, slen);
            do_access(1'b0, 16'h1234 + 16'(c), 8'h00, rd, slen);
            chk("R4", "lower sector strobe", slen, exp_len(2'(c)));
            do_access(1'b0, 16'hC3A5 + 16'(c), 8'h00, rd, slen);
            chk("R4", "upper sector strobe", slen, exp_len(2'(3 - c)));
        end

        // Boundary edges: 0x5FFF lower, 0x6000 upper.
        cfg_bound = 3'd3; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd2;
        do_access(1'b1, 16'h5FFF, 8'h3C, rd, slen);
        chk("R4", "just below boundary", slen, 1);
        do_access(1'b1, 16'h6000, 8'hC3, rd, slen);
        chk("R4", "at boundary", slen, 3);
        do_access(1'b0, 16'h5FFF, 8'h00, rd, slen);
        do_access(1'b0, 16'h6000, 8'h00, rd, slen);
        cfg_bound = 3'd0; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd3;
        do_access(1'b0, 16'h0000, 8'h00, rd, slen);
        chk("R4", "bound zero uses upper", slen, 3);

        // Keeper disabled: bus free for another agent while idle.
        cfg_keep_en = 1'b0;
        do_access(1'b1, 16'h0777, 8'h99, rd, slen);
        tb_val = 8'hA5; tb_oe = 1'b1;
        #1;
        chk("R9", "bus free when keeper off", ad_bus, 8'hA5);
        @(negedge clk);
        tb_val = 8'h5A;
        #1;
        chk("R9", "bus free second value", ad_bus, 8'h5A);
        tb_oe = 1'b0;
        cfg_keep_en = 1'b1;
        do_access(1'b0, 16'h0777, 8'h00, rd, slen);

        // Seeded random traffic over a pool of addresses.
        for (int i = 0; i < 16; i++) begin
            pool[i] = 16'($urandom());
            do_access(1'b1, pool[i], 8'($urandom()), rd, slen);
        end
        for (int i = 0; i < 240; i++) begin
            if (i % 20 == 0) begin
                cfg_bound   = 3'($urandom());
                cfg_wait_lo = 2'($urandom());
                cfg_wait_hi = 2'($urandom());
            end
            do_access(1'($urandom()), pool[$urandom() % 16], 8'($urandom()), rd, slen);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule